// File: doc/BRIEF.md
# Reloading Counter/Timer Channel

This block is a single channel of a programmable counter/timer. An 8-bit downcounter is decremented either by a prescaled system clock (timer mode, divide by 16 or by 256) or by edges on an external trigger input (counter mode). The edge polarity is selectable. When the count runs out, the channel reloads the stored time constant and carries on without help from software. It also emits a one-cycle zero pulse and, if enabled, raises an interrupt request that stays up until acknowledged.

Software drives the channel through one byte-wide write stream. A byte is a control word unless the channel is waiting for a time constant. A control word with the follow-up flag set makes the channel wait: the channel halts, and the next byte written becomes the time constant, which starts counting again. The live count is always visible on a read port. The write stream has no back-pressure: `wr_ready` is high whenever reset is low, and a byte is taken on each clock edge where `wr_valid` and `wr_ready` are both high.

Control word bits: bit0 interrupt enable, bit1 counter mode (0 = timer), bit2 prescale 256 (0 = 16), bit3 rising edge (0 = falling), bit4 timer waits for trigger, bit5 time constant follows, bit6 halt, bit7 unused.

Top module: `ctr_chan`

## Requirements
- R1: After synchronous reset the count reads 0, the zero pulse and the interrupt request are low, and the channel does not count until it is programmed.
- R2: In timer mode the count decrements once every 16 clocks when control bit2 is 0, and once every 256 clocks when bit2 is 1. Zero pulses come exactly time-constant times that divisor clocks after the time-constant write edge.
- R3: A time constant of 0 counts 256 decrements between reloads.
- R4: On reaching zero the count is reloaded from the time constant and counting continues, so zero pulses repeat with the same period.
- R5: Each time zero is reached, `zero_pulse` is high for exactly one clock.
- R6: When bit0 is set, reaching zero sets `irq_req`, which stays high until `irq_ack`. When bit0 is clear, `irq_req` never rises.
- R7: In counter mode the count decrements once per qualifying trigger edge (bit3 = 1 rising, 0 falling). Edges of the other polarity have no effect on the count.
- R8: In timer mode with bit4 set, the count holds at the time constant after the load until a qualifying trigger edge arrives, and then timing starts.
- R9: A control word with bit5 set halts the channel and freezes the count until the next byte, which is loaded as the time constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Write byte accepted (high out of reset) |
| wr_data | input | 8 | Control word or time constant |
| trig_in | input | 1 | Asynchronous external clock/trigger |
| irq_ack | input | 1 | Clears the interrupt request |
| rd_count | output | 8 | Current downcounter value |
| zero_pulse | output | 1 | One-cycle pulse at zero count |
| irq_req | output | 1 | Interrupt request |

## Verification
The bench builds the channel with its default parameters: an 8-bit count, a two-flop synchroniser and prescale exponents 4 and 8. With these values both divisors give short exact periods that can be checked cycle for cycle, and the time-constant-zero case of 256 × 16 clocks still fits easily in the run. Counter-mode and trigger-start cases are checked through the count value once the synchroniser has settled, not at an exact cycle.

// File: rtl/ctr_chan_pkg.sv
package ctr_chan_pkg;
  typedef struct packed {
    logic spare;
    logic halt;
    logic tc_follows;
    logic trig_start;
    logic edge_rise;
    logic pre_hi;
    logic ctr_mode;
    logic irq_en;
  } ctl_t;
endpackage

// File: rtl/ctr_chan_sync.sv
module ctr_chan_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic rise_sel,
  output logic edge_o
);
  logic [STAGES:0] chain;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) chain[0] <= rst ? 1'b0 : din;
      end else begin : g_next
        always_ff @(posedge clk) chain[g] <= rst ? 1'b0 : chain[g-1];
      end
    end
  endgenerate

  logic cur, prev;
  assign cur  = chain[STAGES-1];
  assign prev = chain[STAGES];
  assign edge_o = rise_sel ? (cur & ~prev) : (~cur & prev);

  p_edge_single_r7: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> !edge_o);
endmodule

// File: rtl/ctr_chan_presc.sv
module ctr_chan_presc #(
  parameter int LO_LOG = 4,
  parameter int HI_LOG = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic sel_hi,
  output logic tick
);
  logic [HI_LOG-1:0] cnt;

  assign tick = run & (sel_hi ? (&cnt) : (&cnt[LO_LOG-1:0]));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/ctr_chan_regs.sv
module ctr_chan_regs
  import ctr_chan_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_fire,
  input  logic [DW-1:0] wr_data,
  output ctl_t          ctl_o,
  output logic [DW-1:0] tc_o,
  output logic          tc_load_o,
  output logic          stop_o,
  output logic          await_o
);
  ctl_t wr_ctl;
  assign wr_ctl    = ctl_t'(wr_data[7:0]);
  assign tc_load_o = wr_fire & await_o;
  assign stop_o    = wr_fire & ~await_o & (wr_ctl.tc_follows | wr_ctl.halt);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_o   <= '0;
      tc_o    <= '0;
      await_o <= 1'b0;
    end else if (wr_fire) begin
      if (await_o) begin
        tc_o    <= wr_data;
        await_o <= 1'b0;
      end else begin
        ctl_o   <= wr_ctl;
        await_o <= wr_ctl.tc_follows;
      end
    end
  end

  p_await_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (await_o && !wr_fire) |=> await_o);
endmodule

// File: rtl/ctr_chan.sv
module ctr_chan
  import ctr_chan_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int SYNC_STG  = 2,
  parameter int PRE_LO_LG = 4,
  parameter int PRE_HI_LG = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             trig_in,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] rd_count,
  output logic             zero_pulse,
  output logic             irq_req
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  ctl_t             ctl;
  logic [CNT_W-1:0] tc;
  logic             tc_load, stop, await_tc, wr_fire;
  logic             trig_edge, tick, dec;
  logic             running, armed;
  logic [CNT_W-1:0] count;

  assign wr_ready = ~rst;
  assign wr_fire  = wr_valid & wr_ready;

  ctr_chan_regs #(.DW(CNT_W)) regs_i (
    .clk(clk), .rst(rst), .wr_fire(wr_fire), .wr_data(wr_data),
    .ctl_o(ctl), .tc_o(tc), .tc_load_o(tc_load), .stop_o(stop),
    .await_o(await_tc)
  );

  ctr_chan_sync #(.STAGES(SYNC_STG)) sync_i (
    .clk(clk), .rst(rst), .din(trig_in), .rise_sel(ctl.edge_rise),
    .edge_o(trig_edge)
  );

  ctr_chan_presc #(.LO_LOG(PRE_LO_LG), .HI_LOG(PRE_HI_LG)) presc_i (
    .clk(clk), .rst(rst), .run(running & ~ctl.ctr_mode),
    .sel_hi(ctl.pre_hi), .tick(tick)
  );

  assign dec = running & (ctl.ctr_mode ? trig_edge : tick);

  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= '0;
      running    <= 1'b0;
      armed      <= 1'b0;
      zero_pulse <= 1'b0;
      irq_req    <= 1'b0;
    end else begin
      zero_pulse <= 1'b0;
      if (irq_ack || !ctl.irq_en) irq_req <= 1'b0;
      if (stop) begin
        running <= 1'b0;
        armed   <= 1'b0;
      end else if (tc_load) begin
        count <= wr_data;
        if (!ctl.ctr_mode && ctl.trig_start) begin
          armed   <= 1'b1;
          running <= 1'b0;
        end else begin
          armed   <= 1'b0;
          running <= 1'b1;
        end
      end else if (armed && trig_edge) begin
        armed   <= 1'b0;
        running <= 1'b1;
      end else if (dec) begin
        if (count == ONE) begin
          count      <= tc;
          zero_pulse <= 1'b1;
          if (ctl.irq_en) irq_req <= 1'b1;
        end else begin
          count <= count - ONE;
        end
      end
    end
  end

  assign rd_count = count;

  p_zero_single_r5: assert property (@(posedge clk) disable iff (rst)
    zero_pulse |=> !zero_pulse);
  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    zero_pulse |-> (count == tc));
  p_irq_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_ack && ctl.irq_en) |=> irq_req);
  p_irq_gated_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(ctl.irq_en));
  p_halt_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    (await_tc && !wr_fire) |=> $stable(count));
endmodule

// File: tb/ctr_chan_tb.sv
module ctr_chan_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = '0;
  logic       trig_in = 1'b0;
  logic       irq_ack = 1'b0;
  logic [7:0] rd_count;
  logic       zero_pulse;
  logic       irq_req;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int last_ref = 0;
  int pulses = 0;
  int exp_q[$];   // expected interval in clocks, 0 = any
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ctr_chan dut_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .trig_in(trig_in), .irq_ack(irq_ack),
    .rd_count(rd_count), .zero_pulse(zero_pulse), .irq_req(irq_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
    last_ref = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input int limit);
    for (int i = 0; i < limit && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R4 pulses outstanding", exp_q.size(), 0);
  endtask

  task automatic set_trig(input logic v);
    @(negedge clk);
    trig_in = v;
    idle(6);
  endtask

  // monitor: pops expected zero pulses and compares their spacing
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && zero_pulse) begin
        pulses++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected zero pulse", cyc, -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (e != 0) chk(cyc - last_ref == e, "R2 zero pulse interval", cyc - last_ref, e);
        end
        last_ref = cyc;
        @(negedge clk);
        chk(!zero_pulse, "R5 pulse width one clock", zero_pulse, 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p0;
    idle(3);
    @(negedge clk) rst = 1'b0;
    chk(rd_count == 0, "R1 reset count", rd_count, 0);
    chk(!zero_pulse && !irq_req, "R1 reset outputs", {zero_pulse, irq_req}, 0);
    idle(50);
    chk(rd_count == 0, "R1 idle after reset", rd_count, 0);

    // R2 R4 R6: timer /16, tc 5, interrupts on
    exp_q.push_back(80); exp_q.push_back(80); exp_q.push_back(80);
    wr(8'h21); wr(8'd5);
    drain(400);
    chk(irq_req, "R6 irq raised", irq_req, 1);
    idle(3);
    chk(irq_req, "R6 irq held until ack", irq_req, 1);
    @(negedge clk) irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
    chk(!irq_req, "R6 irq cleared by ack", irq_req, 0);

    // R2 R6: timer /256, tc 2, interrupts off
    exp_q.push_back(512); exp_q.push_back(512);
    wr(8'h24); wr(8'd2);
    drain(1200);
    chk(!irq_req, "R6 no irq when disabled", irq_req, 0);

    // R3: tc 0 => 256 counts
    exp_q.push_back(4096);
    wr(8'h20); wr(8'd0);
    drain(4300);

    // R9: halt freezes count
    wr(8'h20);
    p0 = rd_count;
    idle(100);
    chk(rd_count == p0, "R9 count frozen while halted", rd_count, p0);

    // R7 R4: counter mode, rising edges, tc 3
    wr(8'd3);
    wr(8'h2A); wr(8'd3);
    set_trig(1'b1);
    chk(rd_count == 2, "R7 rising edge counted", rd_count, 2);
    set_trig(1'b0);
    chk(rd_count == 2, "R7 falling edge ignored", rd_count, 2);
    set_trig(1'b1); set_trig(1'b0);
    chk(rd_count == 1, "R7 second rising edge", rd_count, 1);
    exp_q.push_back(0);
    set_trig(1'b1);
    chk(rd_count == 3, "R4 counter reload", rd_count, 3);
    chk(exp_q.size() == 0, "R4 counter zero pulse", exp_q.size(), 0);

    // R7: counter mode, falling edges, tc 4
    wr(8'h22); wr(8'd4);
    set_trig(1'b0);
    chk(rd_count == 3, "R7 falling edge counted", rd_count, 3);
    set_trig(1'b1);
    chk(rd_count == 3, "R7 rising edge ignored", rd_count, 3);

    // R8: timer waits for trigger (rising), tc 2, /16
    set_trig(1'b0);
    wr(8'h38); wr(8'd2);
    idle(100);
    chk(rd_count == 2, "R8 holds before trigger", rd_count, 2);
    exp_q.push_back(0);
    set_trig(1'b1);
    idle(40);
    chk(exp_q.size() == 0, "R8 timing started by trigger", exp_q.size(), 0);
    wr(8'h20);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule